// File: doc/BRIEF.md
# Translation Table Update Engine

This block carries out maintenance commands on a set of I/O address translation tables. A command names a window by a 64-bit identifier, gives a bus address inside that window, and gives either an entry value or the address of a list of entry values in memory, plus a page count. Four operations exist. Put writes one entry. Get reads one entry back. Fill writes one value into a run of consecutive pages. List load copies a run of entries from a list held in memory. For every command the engine returns one status, either success or a parameter error. Get also returns the stored entry.

Each window is described by configuration inputs: an enable, a 32-bit identifier, a base bus offset, a page shift and a table size in entries. The table storage sits outside the block, behind a write port and a read port with one cycle of read latency. List entries arrive through a 64-bit memory read port. The request side of that port uses valid/ready, and the response comes back as a single-cycle valid. Each entry write is followed by an invalidate notification on a valid/ready output. The engine holds that notification until the sink takes it. Back-pressure on it stalls the whole command: no further fetch or write starts until the notification has been accepted.

Commands use a valid/ready handshake. The engine takes one command at a time. It shows busy from acceptance until the status pulse, and it does not offer ready while busy.

Top module: `xlt_update_engine`

## Requirements
- R1: After reset, busy is 0, cmd_ready is 1, and rsp_valid, ntf_valid, tbl_we, tbl_re and mem_req_valid are all 0.
- R2: Put (cmd_op 0) first aligns the bus address down to the window's page size. It then writes cmd_arg to entry index (aligned address − base) >> page shift of the selected window, and returns success. For put and get, cmd_count is ignored.
- R3: If the computed index is at or above the window size, the status is a parameter error and nothing is written. This includes an address below the base, which wraps to a large index.
- R4: If the window identifier has any of bits 63:32 set, or matches no enabled window, the status is a parameter error with no write and no fetch. When several windows match, the lowest-numbered matching window is used.
- R5: Get (cmd_op 1) returns the stored entry on rsp_data with success and leaves the table unchanged. rsp_data is zero for every status other than a successful get.
- R6: Fill (cmd_op 2) writes cmd_arg to cmd_count consecutive pages. If cmd_count is zero or greater than the window size, the command is rejected before any write.
- R7: List load (cmd_op 3) is rejected before any fetch if cmd_count is zero, if cmd_count exceeds 512, or if cmd_arg has any of bits 11:0 set.
- R8: List entry k is fetched from address cmd_arg + 8·k. Its value is the byte reversal of mem_rsp_data: bits 7:0 hold the byte at the lowest address, and that byte becomes the entry's most significant byte.
- R9: Multi-page commands advance the bus address by one page per entry and stop at the first failing page. The status is then a parameter error, and entries already written keep their values.
- R10: After each write, one notification carries the window number, iova = relative aligned address masked to the page, xlat = entry value with its offset bits cleared, mask = page size − 1, and perm = entry bits 1:0 (0 none, 1 read, 2 write, 3 read-write).
- R11: While ntf_valid is high and ntf_ready is low, ntf_valid stays high and all notification fields stay stable. No further fetch, write or status occurs until the notification is accepted.
- R12: busy rises in the cycle after a command is accepted and stays high through the single-cycle rsp_valid pulse. cmd_ready is low whenever busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 2 | 0 put, 1 get, 2 fill, 3 list load |
| cmd_win | input | 64 | Window identifier |
| cmd_addr | input | 64 | Bus address |
| cmd_arg | input | 64 | Entry value or list address |
| cmd_count | input | CNT_W | Page count |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Status pulse |
| rsp_err | output | 1 | 1 = parameter error |
| rsp_data | output | 64 | Entry returned by a successful get |
| cfg_en | input | NUM_WIN | Window enables |
| cfg_id | input | NUM_WIN*32 | Window identifiers |
| cfg_base | input | NUM_WIN*64 | Window base bus offsets |
| cfg_shift | input | NUM_WIN*6 | Window page shifts |
| cfg_size | input | NUM_WIN*(IDX_W+1) | Window sizes in entries |
| tbl_we | output | 1 | Table write strobe |
| tbl_re | output | 1 | Table read strobe, data one cycle later |
| tbl_win | output | WSEL_W | Selected window number |
| tbl_idx | output | IDX_W | Entry index |
| tbl_wdata | output | 64 | Entry write data |
| tbl_rdata | input | 64 | Entry read data |
| mem_req_valid | output | 1 | List fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 64 | Fetch address |
| mem_rsp_valid | input | 1 | Fetch data present |
| mem_rsp_data | input | 64 | Fetch data, lowest-address byte in bits 7:0 |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Notification taken |
| ntf_win | output | WSEL_W | Window of the written entry |
| ntf_iova | output | 64 | Page-aligned relative bus address |
| ntf_xlat | output | 64 | Translated page address |
| ntf_mask | output | 64 | Offset mask |
| ntf_perm | output | 2 | Decoded permission |

## Verification
A wrong window choice or a bad index calculation shows up within one command. Either the write count or the status differs from expectation, or a later get through the same ports returns the wrong entry. A page counter that is off by one in a multi-page walk shows up as one write too many or too few, and as a success/error flip on the status pulse. A fault in the notification register shows up within the back-pressure window as changing fields or a dropped valid. A byte-order fault on list fetches appears as soon as a loaded entry is read back.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHK,
    S_FREQ,
    S_FWAIT,
    S_STEP,
    S_NTF,
    S_RD,
    S_RDW,
    S_DONE
  } state_e;

  function automatic perm_e perm_of(input logic [63:0] entry);
    case (entry[1:0])
      2'd0:    perm_of = PERM_NONE;
      2'd1:    perm_of = PERM_RD;
      2'd2:    perm_of = PERM_WR;
      default: perm_of = PERM_RW;
    endcase
  endfunction

  function automatic logic [63:0] byte_rev(input logic [63:0] w);
    for (int b = 0; b < 8; b++) byte_rev[8*b +: 8] = w[8*(7-b) +: 8];
  endfunction

endpackage

// File: rtl/xlt_win_sel.sv
module xlt_win_sel #(
  parameter int NUM_WIN = 2,
  parameter int IDX_W   = 10,
  localparam int WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int SIZE_W = IDX_W + 1
) (
  input  logic [63:0]               win_id,
  input  logic [NUM_WIN-1:0]        cfg_en,
  input  logic [NUM_WIN*32-1:0]     cfg_id,
  input  logic [NUM_WIN*64-1:0]     cfg_base,
  input  logic [NUM_WIN*6-1:0]      cfg_shift,
  input  logic [NUM_WIN*SIZE_W-1:0] cfg_size,
  output logic                      hit,
  output logic [WSEL_W-1:0]         sel,
  output logic [63:0]               base,
  output logic [5:0]                shift,
  output logic [SIZE_W-1:0]         size
);

  logic [NUM_WIN-1:0] match;
  logic               upper_clear;

  assign upper_clear = (win_id[63:32] == 32'd0);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    assign match[g] = cfg_en[g] && (cfg_id[g*32 +: 32] == win_id[31:0]);
  end

  // lowest-numbered match wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = WSEL_W'(i);
      end
    end
    if (!upper_clear) hit = 1'b0;
  end

  assign base  = cfg_base[sel*64 +: 64];
  assign shift = cfg_shift[sel*6 +: 6];
  assign size  = cfg_size[sel*SIZE_W +: SIZE_W];

endmodule

// File: rtl/xlt_page_math.sv
module xlt_page_math #(
  parameter int IDX_W   = 10,
  localparam int SIZE_W = IDX_W + 1
) (
  input  logic [63:0]       addr,
  input  logic [63:0]       base,
  input  logic [5:0]        shift,
  input  logic [SIZE_W-1:0] size,
  output logic [63:0]       page_size,
  output logic [63:0]       page_mask,
  output logic [63:0]       aligned,
  output logic [63:0]       rel,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);

  logic [63:0] idx_full;

  assign page_size = 64'd1 << shift;
  assign page_mask = ~(page_size - 64'd1);
  assign aligned   = addr & page_mask;
  assign rel       = aligned - base;
  assign idx_full  = rel >> shift;
  assign in_range  = (idx_full < {{(64-SIZE_W){1'b0}}, size});
  assign idx       = idx_full[IDX_W-1:0];

endmodule

// File: rtl/xlt_ntf_reg.sv
module xlt_ntf_reg #(
  parameter int WSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WSEL_W-1:0] in_win,
  input  logic [63:0]       in_iova,
  input  logic [63:0]       in_xlat,
  input  logic [63:0]       in_mask,
  input  logic [1:0]        in_perm,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [WSEL_W-1:0] ntf_win,
  output logic [63:0]       ntf_iova,
  output logic [63:0]       ntf_xlat,
  output logic [63:0]       ntf_mask,
  output logic [1:0]        ntf_perm
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_win   <= '0;
      ntf_iova  <= '0;
      ntf_xlat  <= '0;
      ntf_mask  <= '0;
      ntf_perm  <= '0;
    end else if (load) begin
      ntf_valid <= 1'b1;
      ntf_win   <= in_win;
      ntf_iova  <= in_iova;
      ntf_xlat  <= in_xlat;
      ntf_mask  <= in_mask;
      ntf_perm  <= in_perm;
    end else if (ntf_valid && ntf_ready) begin
      ntf_valid <= 1'b0;
    end
  end

  // R11
  ntf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_iova) && $stable(ntf_xlat)
      && $stable(ntf_mask) && $stable(ntf_perm) && $stable(ntf_win));

endmodule

// File: rtl/xlt_update_engine.sv
module xlt_update_engine
  import xlt_pkg::*;
#(
  parameter int NUM_WIN    = 2,
  parameter int IDX_W      = 10,
  parameter int CNT_W      = 16,
  parameter int LIST_MAX   = 512,
  parameter int LIST_ALIGN = 12,
  localparam int WSEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int SIZE_W    = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [63:0]               cmd_win,
  input  logic [63:0]               cmd_addr,
  input  logic [63:0]               cmd_arg,
  input  logic [CNT_W-1:0]          cmd_count,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [63:0]               rsp_data,
  input  logic [NUM_WIN-1:0]        cfg_en,
  input  logic [NUM_WIN*32-1:0]     cfg_id,
  input  logic [NUM_WIN*64-1:0]     cfg_base,
  input  logic [NUM_WIN*6-1:0]      cfg_shift,
  input  logic [NUM_WIN*SIZE_W-1:0] cfg_size,
  output logic                      tbl_we,
  output logic                      tbl_re,
  output logic [WSEL_W-1:0]         tbl_win,
  output logic [IDX_W-1:0]          tbl_idx,
  output logic [63:0]               tbl_wdata,
  input  logic [63:0]               tbl_rdata,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [63:0]               mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [63:0]               mem_rsp_data,
  output logic                      ntf_valid,
  input  logic                      ntf_ready,
  output logic [WSEL_W-1:0]         ntf_win,
  output logic [63:0]               ntf_iova,
  output logic [63:0]               ntf_xlat,
  output logic [63:0]               ntf_mask,
  output logic [1:0]                ntf_perm
);

  localparam logic [CNT_W+1:0] LIST_LIMIT = (CNT_W+2)'(LIST_MAX);

  state_e            state;
  op_e               op_q;
  logic [63:0]       win_q;
  logic [63:0]       cur_addr;
  logic [63:0]       arg_q;
  logic [63:0]       wr_data;
  logic [CNT_W-1:0]  cnt_left;
  logic [CNT_W-1:0]  ent_no;
  logic              err_q;
  logic [63:0]       data_q;

  logic              ws_hit;
  logic [WSEL_W-1:0] ws_sel;
  logic [63:0]       ws_base;
  logic [5:0]        ws_shift;
  logic [SIZE_W-1:0] ws_size;

  logic [63:0]       pm_size;
  logic [63:0]       pm_mask;
  logic [63:0]       pm_aligned;
  logic [63:0]       pm_rel;
  logic [IDX_W-1:0]  pm_idx;
  logic              pm_ok;

  logic              chk_err;
  logic              fill_bad;
  logic              list_bad;
  logic              ntf_load;
  logic              ntf_fire;
  logic              last_page;

  xlt_win_sel #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_win (
    .win_id   (win_q),
    .cfg_en   (cfg_en),
    .cfg_id   (cfg_id),
    .cfg_base (cfg_base),
    .cfg_shift(cfg_shift),
    .cfg_size (cfg_size),
    .hit      (ws_hit),
    .sel      (ws_sel),
    .base     (ws_base),
    .shift    (ws_shift),
    .size     (ws_size)
  );

  xlt_page_math #(.IDX_W(IDX_W)) u_pm (
    .addr     (cur_addr),
    .base     (ws_base),
    .shift    (ws_shift),
    .size     (ws_size),
    .page_size(pm_size),
    .page_mask(pm_mask),
    .aligned  (pm_aligned),
    .rel      (pm_rel),
    .idx      (pm_idx),
    .in_range (pm_ok)
  );

  // command-level parameter checks, evaluated once in S_CHK
  always_comb begin
    fill_bad = (cnt_left == '0) ||
               ({{(CNT_W+2-SIZE_W){1'b0}}, ws_size} < {2'b00, cnt_left});
    list_bad = (cnt_left == '0) || ({2'b00, cnt_left} > LIST_LIMIT) ||
               (arg_q[LIST_ALIGN-1:0] != '0);
    chk_err  = !ws_hit ||
               (op_q == OP_FILL && fill_bad) ||
               (op_q == OP_LIST && list_bad);
  end

  assign ntf_load  = (state == S_STEP) && pm_ok;
  assign ntf_fire  = (state == S_NTF) && ntf_valid && ntf_ready;
  assign last_page = (cnt_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_PUT;
      win_q    <= '0;
      cur_addr <= '0;
      arg_q    <= '0;
      wr_data  <= '0;
      cnt_left <= '0;
      ent_no   <= '0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q     <= op_e'(cmd_op);
            win_q    <= cmd_win;
            cur_addr <= cmd_addr;
            arg_q    <= cmd_arg;
            cnt_left <= cmd_count;
            ent_no   <= '0;
            err_q    <= 1'b0;
            data_q   <= '0;
            state    <= S_CHK;
          end
        end
        S_CHK: begin
          cur_addr <= pm_aligned;
          wr_data  <= arg_q;
          if (chk_err) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            case (op_q)
              OP_PUT:  begin cnt_left <= CNT_W'(1); state <= S_STEP; end
              OP_GET:  begin cnt_left <= CNT_W'(1); state <= S_RD;   end
              OP_FILL: state <= S_STEP;
              default: state <= S_FREQ;
            endcase
          end
        end
        S_FREQ: begin
          if (mem_req_ready) state <= S_FWAIT;
        end
        S_FWAIT: begin
          if (mem_rsp_valid) begin
            wr_data <= byte_rev(mem_rsp_data);
            state   <= S_STEP;
          end
        end
        S_STEP: begin
          if (pm_ok) begin
            state <= S_NTF;
          end else begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_NTF: begin
          if (ntf_fire) begin
            cnt_left <= cnt_left - CNT_W'(1);
            cur_addr <= cur_addr + pm_size;
            ent_no   <= ent_no + CNT_W'(1);
            if (last_page)            state <= S_DONE;
            else if (op_q == OP_LIST) state <= S_FREQ;
            else                      state <= S_STEP;
          end
        end
        S_RD: begin
          if (pm_ok) begin
            state <= S_RDW;
          end else begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_RDW: begin
          data_q <= tbl_rdata;
          state  <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign rsp_valid     = (state == S_DONE);
  assign rsp_err       = err_q;
  assign rsp_data      = data_q;

  assign tbl_we        = ntf_load;
  assign tbl_re        = (state == S_RD) && pm_ok;
  assign tbl_win       = ws_sel;
  assign tbl_idx       = pm_idx;
  assign tbl_wdata     = wr_data;

  assign mem_req_valid = (state == S_FREQ);
  assign mem_req_addr  = arg_q + {{(61-CNT_W){1'b0}}, ent_no, 3'b000};

  xlt_ntf_reg #(.WSEL_W(WSEL_W)) u_ntf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ntf_load),
    .in_win   (ws_sel),
    .in_iova  (pm_rel & pm_mask),
    .in_xlat  (wr_data & pm_mask),
    .in_mask  (~pm_mask),
    .in_perm  (perm_of(wr_data)),
    .ntf_valid(ntf_valid),
    .ntf_ready(ntf_ready),
    .ntf_win  (ntf_win),
    .ntf_iova (ntf_iova),
    .ntf_xlat (ntf_xlat),
    .ntf_mask (ntf_mask),
    .ntf_perm (ntf_perm)
  );

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready);

  // R12
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && !rsp_valid);

  // R3
  write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ({1'b0, tbl_idx} < ws_size));

  // R10
  write_then_ntf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> ntf_valid);

  // R8
  fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbl_we, tbl_re, mem_req_valid, ntf_valid, rsp_valid}));

  // R5
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> (rsp_data == 64'd0));

endmodule

// File: tb/tb_xlt_update_engine.sv
module tb_xlt_update_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_WIN = 2;
  localparam int IDX_W = 10;
  localparam int CNT_W = 16;
  localparam int SIZE_W = IDX_W + 1;
  localparam int WSEL_W = 1;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = '0;
  logic [63:0]       cmd_win = '0, cmd_addr = '0, cmd_arg = '0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic              busy, rsp_valid, rsp_err;
  logic [63:0]       rsp_data;
  logic [NUM_WIN-1:0]        cfg_en;
  logic [NUM_WIN*32-1:0]     cfg_id;
  logic [NUM_WIN*64-1:0]     cfg_base;
  logic [NUM_WIN*6-1:0]      cfg_shift;
  logic [NUM_WIN*SIZE_W-1:0] cfg_size;
  logic              tbl_we, tbl_re;
  logic [WSEL_W-1:0] tbl_win;
  logic [IDX_W-1:0]  tbl_idx;
  logic [63:0]       tbl_wdata;
  logic [63:0]       tbl_rdata = '0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic [63:0]       mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic              ntf_valid;
  logic              ntf_ready = 1'b1;
  logic [WSEL_W-1:0] ntf_win;
  logic [63:0]       ntf_iova, ntf_xlat, ntf_mask;
  logic [1:0]        ntf_perm;

  // window 0: id 0x10, base 0x1000_0000, 4 KiB pages, 16 entries
  // window 1: id 0x2000_0001, base 0, 64 KiB pages, 8 entries
  assign cfg_en    = 2'b11;
  assign cfg_id    = {32'h2000_0001, 32'h0000_0010};
  assign cfg_base  = {64'h0, 64'h1000_0000};
  assign cfg_shift = {6'd16, 6'd12};
  assign cfg_size  = {11'd8, 11'd16};

  xlt_update_engine dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_win(cmd_win), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .cfg_en(cfg_en), .cfg_id(cfg_id), .cfg_base(cfg_base), .cfg_shift(cfg_shift),
    .cfg_size(cfg_size),
    .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_win(tbl_win), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_win(ntf_win),
    .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat), .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
  );

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    mem_word = {a[31:0], 32'h89AB_CDEF};
  endfunction

  function automatic logic [63:0] rev8(input logic [63:0] w);
    for (int b = 0; b < 8; b++) rev8[8*b +: 8] = w[8*(7-b) +: 8];
  endfunction

  // bench-side table and memory models
  logic [63:0] tab [2][1024] = '{default: '0};
  int n_wr = 0, n_fetch = 0, n_ntf = 0;
  logic [63:0] fetch_log [4];

  always @(posedge clk) begin
    if (tbl_we) begin
      tab[tbl_win][tbl_idx] <= tbl_wdata;
      n_wr <= n_wr + 1;
    end
    if (tbl_re) tbl_rdata <= tab[tbl_win][tbl_idx];
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_word(mem_req_addr);
    if (mem_req_valid && mem_req_ready) begin
      fetch_log[n_fetch % 4] <= mem_req_addr;
      n_fetch <= n_fetch + 1;
    end
    if (ntf_valid && ntf_ready) n_ntf <= n_ntf + 1;
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [63:0] win,
                      input logic [63:0] addr, input logic [63:0] arg,
                      input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_win = win; cmd_addr = addr; cmd_arg = arg; cmd_count = cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic err, output logic [63:0] data);
    int guard = 0;
    while (!rsp_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    err = rsp_err;
    data = rsp_data;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [63:0] win,
                         input logic [63:0] addr, input logic [63:0] arg,
                         input logic [CNT_W-1:0] cnt, output logic err,
                         output logic [63:0] data, output int dwr,
                         output int dfetch, output int dntf);
    int w0, f0, n0;
    w0 = n_wr; f0 = n_fetch; n0 = n_ntf;
    send(op, win, addr, arg, cnt);
    wait_rsp(err, data);
    dwr = n_wr - w0; dfetch = n_fetch - f0; dntf = n_ntf - n0;
  endtask

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic [63:0] win;
    logic [63:0] addr;
    logic [63:0] arg;
    logic [15:0] cnt;
    logic        err;
    logic [63:0] data;
    logic [7:0]  nwr;
    logic [7:0]  nfetch;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  2'd0, 64'h10,          64'h1000_0123, 64'hAAAA_0003, 16'd1,   1'b0, 64'h0,          8'd1, 8'd0}, // R2 idx0
    '{8'd2,  2'd0, 64'h10,          64'h1000_F000, 64'h5,         16'd7,   1'b0, 64'h0,          8'd1, 8'd0}, // R2 idx15, count ignored
    '{8'd3,  2'd0, 64'h10,          64'h1001_0000, 64'h9,         16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R3 idx16
    '{8'd3,  2'd0, 64'h10,          64'h0FFF_F000, 64'h9,         16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R3 below base
    '{8'd4,  2'd0, 64'h1_0000_0010, 64'h1000_0000, 64'h9,         16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R4 upper bits
    '{8'd4,  2'd0, 64'h11,          64'h1000_0000, 64'h9,         16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R4 no match
    '{8'd5,  2'd1, 64'h10,          64'h1000_0FFF, 64'h0,         16'd1,   1'b0, 64'hAAAA_0003,  8'd0, 8'd0}, // R5 get
    '{8'd5,  2'd1, 64'h10,          64'h1001_0000, 64'h0,         16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R5 get out of range
    '{8'd5,  2'd1, 64'h10,          64'h1000_5000, 64'h0,         16'd1,   1'b0, 64'h0,          8'd0, 8'd0}, // R5 unwritten entry
    '{8'd6,  2'd2, 64'h2000_0001,   64'h0002_0000, 64'h7777_0001, 16'd3,   1'b0, 64'h0,          8'd3, 8'd0}, // R6 fill idx2..4
    '{8'd6,  2'd2, 64'h2000_0001,   64'h0000_0000, 64'h1,         16'd9,   1'b1, 64'h0,          8'd0, 8'd0}, // R6 count > size
    '{8'd6,  2'd2, 64'h2000_0001,   64'h0000_0000, 64'h1,         16'd0,   1'b1, 64'h0,          8'd0, 8'd0}, // R6 count zero
    '{8'd9,  2'd2, 64'h2000_0001,   64'h0006_0000, 64'h7777_0001, 16'd4,   1'b1, 64'h0,          8'd2, 8'd0}, // R9 stops at idx8
    '{8'd9,  2'd1, 64'h2000_0001,   64'h0007_FFFF, 64'h0,         16'd1,   1'b0, 64'h7777_0001,  8'd0, 8'd0}, // R9 kept
    '{8'd8,  2'd3, 64'h10,          64'h1000_2000, 64'h8000,      16'd2,   1'b0, 64'h0,          8'd2, 8'd2}, // R8 list ok
    '{8'd7,  2'd3, 64'h10,          64'h1000_2000, 64'h8000,      16'd513, 1'b1, 64'h0,          8'd0, 8'd0}, // R7 too long
    '{8'd7,  2'd3, 64'h10,          64'h1000_2000, 64'h8008,      16'd1,   1'b1, 64'h0,          8'd0, 8'd0}, // R7 misaligned
    '{8'd7,  2'd3, 64'h10,          64'h1000_2000, 64'h8000,      16'd0,   1'b1, 64'h0,          8'd0, 8'd0}, // R7 zero
    '{8'd9,  2'd3, 64'h10,          64'h1000_E000, 64'h9000,      16'd4,   1'b1, 64'h0,          8'd2, 8'd3}  // R9 list stops
  };

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail + 1);
    $finish;
  end

  initial begin : main
    logic err;
    logic [63:0] data, n_iova, n_xlat, n_mask;
    logic [1:0] n_perm;
    logic [WSEL_W-1:0] n_win;
    int dwr, dfetch, dntf;
    bit held;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && cmd_ready && !rsp_valid && !ntf_valid && !tbl_we && !tbl_re
          && !mem_req_valid, "R1 reset", {busy, cmd_ready, rsp_valid, ntf_valid},
          64'h4);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_cmd(VECS[v].op, VECS[v].win, VECS[v].addr, VECS[v].arg, VECS[v].cnt,
              err, data, dwr, dfetch, dntf);
      check(err == VECS[v].err, $sformatf("R%0d vec%0d status", VECS[v].req, v),
            64'(err), 64'(VECS[v].err));
      check(data == VECS[v].data, $sformatf("R%0d vec%0d data", VECS[v].req, v),
            data, VECS[v].data);
      check(dwr == int'(VECS[v].nwr), $sformatf("R%0d vec%0d writes", VECS[v].req, v),
            64'(dwr), 64'(VECS[v].nwr));
      check(dfetch == int'(VECS[v].nfetch), $sformatf("R%0d vec%0d fetches", VECS[v].req, v),
            64'(dfetch), 64'(VECS[v].nfetch));
      // R10 one notification per write
      check(dntf == dwr, $sformatf("R10 vec%0d notifications", v), 64'(dntf), 64'(dwr));
    end

    // R8 byte order on list entries loaded by the vectors
    run_cmd(2'd1, 64'h10, 64'h1000_2000, 64'h0, 16'd1, err, data, dwr, dfetch, dntf);
    check(!err && data == rev8(mem_word(64'h8000)), "R8 list entry0", data, rev8(mem_word(64'h8000)));
    run_cmd(2'd1, 64'h10, 64'h1000_3000, 64'h0, 16'd1, err, data, dwr, dfetch, dntf);
    check(!err && data == rev8(mem_word(64'h8008)), "R8 list entry1", data, rev8(mem_word(64'h8008)));
    run_cmd(2'd1, 64'h10, 64'h1000_F000, 64'h0, 16'd1, err, data, dwr, dfetch, dntf);
    check(!err && data == rev8(mem_word(64'h9008)), "R9 list kept", data, rev8(mem_word(64'h9008)));

    // R8 fetch addresses step by 8
    run_cmd(2'd3, 64'h2000_0001, 64'h0, 64'hA000, 16'd2, err, data, dwr, dfetch, dntf);
    check(!err && dfetch == 2, "R8 list win1 status", 64'(dfetch), 64'd2);
    check(fetch_log[(n_fetch - 2) % 4] == 64'hA000, "R8 fetch addr0",
          fetch_log[(n_fetch - 2) % 4], 64'hA000);
    check(fetch_log[(n_fetch - 1) % 4] == 64'hA008, "R8 fetch addr1",
          fetch_log[(n_fetch - 1) % 4], 64'hA008);

    // R11 back-pressure, R10 notification fields, R12 busy
    ntf_ready = 1'b0;
    send(2'd0, 64'h2000_0001, 64'h0003_1234, 64'h1234_5678_9ABC_DEF2, 16'd1);
    for (int k = 0; k < 20 && !ntf_valid; k++) @(negedge clk);
    n_win = ntf_win; n_iova = ntf_iova; n_xlat = ntf_xlat; n_mask = ntf_mask; n_perm = ntf_perm;
    held = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!ntf_valid || rsp_valid || ntf_iova != n_iova || ntf_xlat != n_xlat ||
          ntf_mask != n_mask || ntf_perm != n_perm || ntf_win != n_win) held = 1'b0;
    end
    check(held, "R11 notification held", 64'(held), 64'd1);
    check(busy && !cmd_ready, "R12 busy while stalled", {busy, cmd_ready}, 64'h2);
    check(n_win == 1'b1, "R10 ntf window", 64'(n_win), 64'd1);
    check(n_iova == 64'h3_0000, "R10 ntf iova", n_iova, 64'h3_0000);
    check(n_xlat == 64'h1234_5678_9ABC_0000, "R10 ntf xlat", n_xlat, 64'h1234_5678_9ABC_0000);
    check(n_mask == 64'hFFFF, "R10 ntf mask", n_mask, 64'hFFFF);
    check(n_perm == 2'd2, "R10 ntf perm", 64'(n_perm), 64'd2);
    ntf_ready = 1'b1;
    wait_rsp(err, data);
    check(!err && rsp_valid, "R11 completes after release", 64'(err), 64'd0);
    @(negedge clk);
    check(!busy && cmd_ready && !rsp_valid, "R12 idle after status",
          {busy, cmd_ready, rsp_valid}, 64'h2);
    run_cmd(2'd1, 64'h2000_0001, 64'h0003_0000, 64'h0, 16'd1, err, data, dwr, dfetch, dntf);
    check(data == 64'h1234_5678_9ABC_DEF2, "R2 put readback", data, 64'h1234_5678_9ABC_DEF2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule